// File: doc/BRIEF.md
# Audio Link Power Sequencer

This block is the controller-side sequencer for the power states of a serial audio codec link. It drives the active-low codec reset line. It drives SYNC while it owns the link during a warm restart. It watches up to two codec serial-data lines for a wake request. It raises a power-management event toward the system when a wake is accepted. Everything runs on a free-running system clock. `CYC_PER_US` gives the number of system cycles per microsecond, and all microsecond timings are derived from it. A small monitor reports whether the codec's bit clock is toggling.

The host sends one-cycle pulses to the block:
- `cold_req` asks for a cold reset.
- `warm_req` asks for a warm restart.
- `pwrdn_issued` reports that a power-down command has gone out to the codec.

The block answers with `frame_en`. This output tells the frame generator that it may run the link. While `frame_en` is low, the frame generator must keep its own SYNC low. The link's SYNC pin is the OR of that generator's SYNC and `sync_out`. There is no data stream through this block: every pin is a plain level or pulse.

After power-down, the link stays quiet for at least four frame times. After that gap, a warm restart may begin. It is started either by a host request or by a qualified wake edge from a codec. It begins only once the bit clock has stopped. The restart raises SYNC for at least 1 µs and then drops it. The block then waits for codec-ready before handing the link back.

Top module: `aclink_pwr_seq`

## Requirements
- R1: After system reset, `ac_rst_n` is low for `RST_US*CYC_PER_US` cycles (1 µs by default), then goes high. `sync_out` and `frame_en` are low throughout.
- R2: After the cold reset ends, `frame_en` stays low until `codec_ready` is high. It rises on the clock edge that samples `codec_ready` high.
- R3: A `cold_req` pulse in any state drives `ac_rst_n` low on the next edge. The full cold-reset timing of R1 then restarts, followed by the codec-ready wait.
- R4: A `pwrdn_issued` pulse while `frame_en` is high drops `frame_en` on the next edge. `sync_out` then stays low for at least `PD_GAP_CYC` cycles (four frame times) before any warm restart.
- R5: `warm_req` is accepted only while the link is powered down. A pulse while `frame_en` is high has no effect: `frame_en` stays high and `sync_out` stays low.
- R6: A warm restart raises `sync_out` only while `bclk_present` is low. It holds `sync_out` high for `SYNC_US*CYC_PER_US` cycles. A pending request waits for as long as the bit clock keeps running.
- R7: During a warm restart, `ac_rst_n` stays high. After SYNC falls, `frame_en` stays low until `codec_ready` is seen.
- R8: `bclk_present` goes low once no bit-clock edge has been seen for `ABSENT_CYC` system cycles. It goes high again within a few cycles of the bit clock restarting.
- R9: While powered down, either `sdin` line can start a wake. The line must be seen low first, then go high and stay high for `WAKE_US*CYC_PER_US` cycles. A qualified wake sets `pme`, and a warm restart follows without any host request.
- R10: A high pulse on an `sdin` line shorter than the qualification time is ignored: `pme` stays low and no warm restart starts.
- R11: `pme` stays high until a `pme_ack` pulse, and is low on the edge after the acknowledge.
- R12: `sdin` activity while `frame_en` is high has no effect on `pme`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| bit_clk | input | 1 | Codec bit clock, asynchronous, used only for presence detection |
| sdin | input | LANES | Codec serial-data lines, asynchronous, watched for wake |
| codec_ready | input | 1 | Codec-ready indication decoded from the incoming frame |
| cold_req | input | 1 | One-cycle host request for a cold reset |
| warm_req | input | 1 | One-cycle host request for a warm restart |
| pwrdn_issued | input | 1 | One-cycle pulse: a power-down command has been sent |
| pme_ack | input | 1 | One-cycle pulse clearing `pme` |
| ac_rst_n | output | 1 | Active-low codec reset |
| sync_out | output | 1 | SYNC drive during a warm restart, ORed with the frame generator's SYNC |
| frame_en | output | 1 | Frame generator may run the link |
| bclk_present | output | 1 | Bit clock seen toggling recently |
| pme | output | 1 | Power-management event toward the system |

## Verification
Some properties are checked on every cycle:
- the minimum low time of `ac_rst_n`;
- the minimum high time of `sync_out`;
- that SYNC never rises while the bit clock was present;
- that SYNC never rises sooner than the gap after power-down;
- that `pme` can only fall after an acknowledge and can only rise while the link is down;
- that cold requests take effect at once;
- that warm requests in the active state are ignored.

Other behaviour needs the directed scenarios:
- that a wake is qualified by width;
- that a pending request is held back while the bit clock runs;
- the hand-over through codec-ready;
- the presence monitor's reaction to the bit clock stopping and restarting.

// File: rtl/aclink_pkg.sv
package aclink_pkg;

  typedef enum logic [2:0] {
    ST_COLD     = 3'd0,
    ST_WAIT_RDY = 3'd1,
    ST_ACTIVE   = 3'd2,
    ST_PD_GAP   = 3'd3,
    ST_DOWN     = 3'd4,
    ST_WARM     = 3'd5
  } seq_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/aclink_sync2.sv
module aclink_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/aclink_bclk_mon.sv
module aclink_bclk_mon #(
  parameter int ABSENT_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_clk,
  output logic present
);
  localparam int CW = $clog2(ABSENT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(ABSENT_CYC);

  logic          bclk_s;
  logic          bclk_d;
  logic [CW-1:0] idle_q;
  logic [CW-1:0] idle_n;
  logic          edge_seen;

  aclink_sync2 #(.W(1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (bit_clk),
    .q    (bclk_s)
  );

  assign edge_seen = bclk_s ^ bclk_d;

  always_comb begin
    if (edge_seen)           idle_n = '0;
    else if (idle_q == LIMIT) idle_n = idle_q;
    else                     idle_n = idle_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_d  <= 1'b0;
      idle_q  <= LIMIT;
      present <= 1'b0;
    end else begin
      bclk_d  <= bclk_s;
      idle_q  <= idle_n;
      present <= (idle_n < LIMIT);
    end
  end
endmodule

// File: rtl/aclink_wake_qual.sv
module aclink_wake_qual #(
  parameter int LANES    = 2,
  parameter int WAKE_CYC = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [LANES-1:0] sdin,
  output logic             wake
);
  localparam int CW = $clog2(WAKE_CYC + 1);
  localparam logic [CW-1:0] FULL = CW'(WAKE_CYC);
  localparam logic [CW-1:0] LAST = CW'(WAKE_CYC - 1);

  logic [LANES-1:0] line_s;
  logic [LANES-1:0] hit;

  aclink_sync2 #(.W(LANES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (sdin),
    .q    (line_s)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic          seen_low_q;
    logic [CW-1:0] high_q;

    assign hit[i] = arm && line_s[i] && seen_low_q && (high_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seen_low_q <= 1'b0;
        high_q     <= '0;
      end else if (!arm) begin
        seen_low_q <= 1'b0;
        high_q     <= '0;
      end else if (!line_s[i]) begin
        seen_low_q <= 1'b1;
        high_q     <= '0;
      end else if (seen_low_q && (high_q != FULL)) begin
        high_q <= high_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake <= 1'b0;
    else        wake <= |hit;
  end
endmodule

// File: rtl/aclink_seq_fsm.sv
module aclink_seq_fsm
  import aclink_pkg::*;
#(
  parameter int RST_CYC  = 50,
  parameter int SYNC_CYC = 50,
  parameter int GAP_CYC  = 4167
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cold_req,
  input  logic warm_req,
  input  logic pwrdn_issued,
  input  logic codec_ready,
  input  logic bclk_present,
  input  logic wake,
  output logic ac_rst_n,
  output logic sync_out,
  output logic frame_en,
  output logic arm
);
  localparam int MAXC = int'(max3(RST_CYC, SYNC_CYC, GAP_CYC));
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] RST_LAST  = CW'(RST_CYC - 1);
  localparam logic [CW-1:0] SYNC_LAST = CW'(SYNC_CYC - 1);
  localparam logic [CW-1:0] GAP_LAST  = CW'(GAP_CYC - 1);

  seq_state_e    state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          warm_pend_q, warm_pend_n;
  logic          wake_pend_q, wake_pend_n;
  logic          in_pd, stay_pd;

  assign in_pd   = (state_q == ST_PD_GAP) || (state_q == ST_DOWN);
  assign stay_pd = (state_n == ST_PD_GAP) || (state_n == ST_DOWN);
  assign arm     = in_pd;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q + CW'(1);
    unique case (state_q)
      ST_COLD: begin
        if (cnt_q == RST_LAST) begin
          state_n = ST_WAIT_RDY;
          cnt_n   = '0;
        end
      end
      ST_WAIT_RDY: begin
        cnt_n = '0;
        if (codec_ready) state_n = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        cnt_n = '0;
        if (pwrdn_issued) state_n = ST_PD_GAP;
      end
      ST_PD_GAP: begin
        if (cnt_q == GAP_LAST) begin
          state_n = ST_DOWN;
          cnt_n   = '0;
        end
      end
      ST_DOWN: begin
        cnt_n = '0;
        if ((warm_pend_q || wake_pend_q) && !bclk_present) state_n = ST_WARM;
      end
      ST_WARM: begin
        if (cnt_q == SYNC_LAST) begin
          state_n = ST_WAIT_RDY;
          cnt_n   = '0;
        end
      end
      default: begin
        state_n = ST_COLD;
        cnt_n   = '0;
      end
    endcase
    if (cold_req) begin
      state_n = ST_COLD;
      cnt_n   = '0;
    end
  end

  always_comb begin
    warm_pend_n = stay_pd && in_pd && (warm_pend_q || warm_req);
    wake_pend_n = stay_pd && (wake_pend_q || wake);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_COLD;
      cnt_q       <= '0;
      warm_pend_q <= 1'b0;
      wake_pend_q <= 1'b0;
      ac_rst_n    <= 1'b0;
      sync_out    <= 1'b0;
      frame_en    <= 1'b0;
    end else begin
      state_q     <= state_n;
      cnt_q       <= cnt_n;
      warm_pend_q <= warm_pend_n;
      wake_pend_q <= wake_pend_n;
      ac_rst_n    <= (state_n != ST_COLD);
      sync_out    <= (state_n == ST_WARM);
      frame_en    <= (state_n == ST_ACTIVE);
    end
  end
endmodule

// File: rtl/aclink_pwr_seq.sv
module aclink_pwr_seq #(
  parameter int CYC_PER_US = 50,
  parameter int RST_US     = 1,
  parameter int SYNC_US    = 1,
  parameter int WAKE_US    = 1,
  parameter int PD_GAP_CYC = 4167,
  parameter int ABSENT_CYC = 8,
  parameter int LANES      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_clk,
  input  logic [LANES-1:0] sdin,
  input  logic             codec_ready,
  input  logic             cold_req,
  input  logic             warm_req,
  input  logic             pwrdn_issued,
  input  logic             pme_ack,
  output logic             ac_rst_n,
  output logic             sync_out,
  output logic             frame_en,
  output logic             bclk_present,
  output logic             pme
);
  localparam int RST_CYC  = RST_US * CYC_PER_US;
  localparam int SYNC_CYC = SYNC_US * CYC_PER_US;
  localparam int WAKE_CYC = WAKE_US * CYC_PER_US;

  logic wake;
  logic arm;

  aclink_bclk_mon #(.ABSENT_CYC(ABSENT_CYC)) u_bclk (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_clk(bit_clk),
    .present(bclk_present)
  );

  aclink_wake_qual #(.LANES(LANES), .WAKE_CYC(WAKE_CYC)) u_wake (
    .clk  (clk),
    .rst_n(rst_n),
    .arm  (arm),
    .sdin (sdin),
    .wake (wake)
  );

  aclink_seq_fsm #(.RST_CYC(RST_CYC), .SYNC_CYC(SYNC_CYC), .GAP_CYC(PD_GAP_CYC)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .cold_req    (cold_req),
    .warm_req    (warm_req),
    .pwrdn_issued(pwrdn_issued),
    .codec_ready (codec_ready),
    .bclk_present(bclk_present),
    .wake        (wake),
    .ac_rst_n    (ac_rst_n),
    .sync_out    (sync_out),
    .frame_en    (frame_en),
    .arm         (arm)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pme <= 1'b0;
    else        pme <= wake | (pme & ~pme_ack);
  end
endmodule

// File: rtl/aclink_pwr_seq_chk.sv
module aclink_pwr_seq_chk #(
  parameter int RST_CYC  = 50,
  parameter int SYNC_CYC = 50,
  parameter int GAP_CYC  = 4167
) (
  input logic clk,
  input logic rst_n,
  input logic cold_req,
  input logic warm_req,
  input logic pwrdn_issued,
  input logic pme_ack,
  input logic ac_rst_n,
  input logic sync_out,
  input logic frame_en,
  input logic bclk_present,
  input logic pme
);
  int unsigned rst_lo_cnt;
  int unsigned sync_hi_cnt;
  int unsigned since_pd_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_lo_cnt   <= 0;
      sync_hi_cnt  <= 0;
      since_pd_cnt <= 0;
    end else begin
      rst_lo_cnt  <= ac_rst_n ? 0 : rst_lo_cnt + 1;
      sync_hi_cnt <= sync_out ? sync_hi_cnt + 1 : 0;
      if (frame_en && pwrdn_issued)       since_pd_cnt <= 0;
      else if (since_pd_cnt != 32'hFFFF_FFFF) since_pd_cnt <= since_pd_cnt + 1;
    end
  end

  assert_rst_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ac_rst_n) |-> (rst_lo_cnt >= RST_CYC));

  assert_cold_override_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cold_req |=> !ac_rst_n);

  assert_pd_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_out) |-> (since_pd_cnt >= GAP_CYC));

  assert_warm_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_en && warm_req && !pwrdn_issued && !cold_req) |=> (frame_en && !sync_out));

  assert_sync_no_bclk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_out) |-> !$past(bclk_present));

  assert_sync_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sync_out) && ac_rst_n) |-> (sync_hi_cnt >= SYNC_CYC));

  assert_warm_keeps_rst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_out && !$past(cold_req)) |-> ac_rst_n);

  assert_pme_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pme) |-> $past(pme_ack));

  assert_pme_when_down_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pme) |-> !frame_en);
endmodule

bind aclink_pwr_seq aclink_pwr_seq_chk #(
  .RST_CYC (RST_US * CYC_PER_US),
  .SYNC_CYC(SYNC_US * CYC_PER_US),
  .GAP_CYC (PD_GAP_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cold_req    (cold_req),
  .warm_req    (warm_req),
  .pwrdn_issued(pwrdn_issued),
  .pme_ack     (pme_ack),
  .ac_rst_n    (ac_rst_n),
  .sync_out    (sync_out),
  .frame_en    (frame_en),
  .bclk_present(bclk_present),
  .pme         (pme)
);

// File: tb/tb_aclink_pwr_seq.sv
module tb_aclink_pwr_seq;
  localparam int US   = 50;
  localparam int RSTC = 50;
  localparam int SYNC = 50;
  localparam int WAKE = 50;
  localparam int GAP  = 4167;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_clk = 1'b0;
  logic       bclk_run = 1'b1;
  logic [1:0] sdin = 2'b00;
  logic       codec_ready = 1'b0;
  logic       cold_req = 1'b0;
  logic       warm_req = 1'b0;
  logic       pwrdn_issued = 1'b0;
  logic       pme_ack = 1'b0;
  logic       ac_rst_n, sync_out, frame_en, bclk_present, pme;

  int total = 0;
  int bad = 0;
  int sync_hi_total = 0;
  int rst_lo_total = 0;
  int cyc = 0;

  aclink_pwr_seq #(.CYC_PER_US(US), .PD_GAP_CYC(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .sdin(sdin),
    .codec_ready(codec_ready), .cold_req(cold_req), .warm_req(warm_req),
    .pwrdn_issued(pwrdn_issued), .pme_ack(pme_ack), .ac_rst_n(ac_rst_n),
    .sync_out(sync_out), .frame_en(frame_en), .bclk_present(bclk_present), .pme(pme)
  );

  always #10 clk = ~clk;

  always begin
    #40;
    if (bclk_run) bit_clk = ~bit_clk;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (sync_out) sync_hi_total <= sync_hi_total + 1;
    if (rst_n && !ac_rst_n) rst_lo_total <= rst_lo_total + 1;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_cold();
    cold_req = 1'b1; step(1); cold_req = 1'b0;
  endtask
  task automatic pulse_warm();
    warm_req = 1'b1; step(1); warm_req = 1'b0;
  endtask
  task automatic pulse_pd();
    pwrdn_issued = 1'b1; step(1); pwrdn_issued = 1'b0;
  endtask

  task automatic bring_up(input string req);
    int n;
    bclk_run = 1'b1;
    codec_ready = 1'b1;
    n = 0;
    while (!frame_en && n < 20) begin step(1); n++; end
    check(frame_en == 1'b1, req, frame_en, 1);
  endtask

  task automatic wait_sync_rise(output int n);
    n = 0;
    while (!sync_out && n < GAP + 2000) begin step(1); n++; end
  endtask

  task automatic finish_warm(input string req);
    int n;
    n = 0;
    while (sync_out && n < 200) begin step(1); n++; end
    bring_up(req);
  endtask

  // R1, R2: reset state and cold-reset timing
  task automatic t_reset();
    int n;
    rst_n = 1'b0; step(4);
    check(ac_rst_n == 1'b0 && sync_out == 1'b0 && frame_en == 1'b0, "R1 reset state", ac_rst_n, 0);
    rst_n = 1'b1;
    n = 0;
    while (!ac_rst_n && n < 500) begin step(1); n++; end
    check(n >= RSTC && n <= RSTC + 2, "R1 cold low width", n, RSTC);
    step(10);
    check(frame_en == 1'b0, "R2 wait for ready", frame_en, 0);
    codec_ready = 1'b1; step(1);
    check(frame_en == 1'b1, "R2 frame enable after ready", frame_en, 1);
  endtask

  // R8: bit clock presence
  task automatic t_bclk();
    check(bclk_present == 1'b1, "R8 present while running", bclk_present, 1);
    bclk_run = 1'b0; step(20);
    check(bclk_present == 1'b0, "R8 absent after stop", bclk_present, 0);
    bclk_run = 1'b1; step(10);
    check(bclk_present == 1'b1, "R8 present after restart", bclk_present, 1);
  endtask

  // R5, R12: requests and wake lines ignored while active
  task automatic t_active_ignores();
    int s0;
    s0 = sync_hi_total;
    pulse_warm(); step(60);
    check(frame_en == 1'b1 && sync_hi_total == s0, "R5 warm ignored when active",
          sync_hi_total - s0, 0);
    sdin = 2'b01; step(150); sdin = 2'b00; step(5);
    check(pme == 1'b0, "R12 sdin ignored when active", pme, 0);
  endtask

  // R4, R6, R7: host warm restart after power-down
  task automatic t_host_warm();
    int n, h, r0;
    codec_ready = 1'b0;
    pulse_pd();
    check(frame_en == 1'b0, "R4 frame disable on power-down", frame_en, 0);
    pulse_warm();
    step(20); bclk_run = 1'b0;
    r0 = rst_lo_total;
    wait_sync_rise(n);
    check(n + 22 >= GAP, "R4 gap before sync", n + 22, GAP);
    h = 0;
    while (sync_out && h < 200) begin step(1); h++; end
    check(h >= SYNC && h <= SYNC + 1, "R6 sync high width", h, SYNC);
    check(rst_lo_total == r0, "R7 reset kept high in warm", rst_lo_total - r0, 0);
    step(10);
    check(frame_en == 1'b0, "R7 wait ready after warm", frame_en, 0);
    bring_up("R7 link back after ready");
  endtask

  // R6: pending request held while bit clock runs
  task automatic t_pending_bclk();
    int s0, n;
    codec_ready = 1'b0;
    pulse_pd(); pulse_warm();
    s0 = sync_hi_total;
    step(GAP + 100);
    check(sync_hi_total == s0, "R6 no sync while bit clock runs", sync_hi_total - s0, 0);
    bclk_run = 1'b0;
    n = 0;
    while (!sync_out && n < 100) begin step(1); n++; end
    check(sync_out == 1'b1, "R6 sync after bit clock stops", sync_out, 1);
    finish_warm("R6 recover");
  endtask

  // R9, R10, R11: wake qualification and event handling
  task automatic t_wake();
    int s0, n;
    codec_ready = 1'b0;
    pulse_pd(); step(5); bclk_run = 1'b0;
    step(GAP + 20);
    s0 = sync_hi_total;
    sdin = 2'b10; step(WAKE / 2); sdin = 2'b00; step(100);
    check(pme == 1'b0 && sync_hi_total == s0, "R10 short wake ignored", pme, 0);
    sdin = 2'b10;
    n = 0;
    while (!pme && n < 200) begin step(1); n++; end
    check(pme == 1'b1 && n >= WAKE, "R9 pme after qualified wake", n, WAKE);
    step(3);
    check(sync_out == 1'b1, "R9 automatic warm restart", sync_out, 1);
    n = 0;
    while (sync_out && n < 200) begin step(1); n++; end
    sdin = 2'b00; step(20);
    check(pme == 1'b1, "R11 pme held until ack", pme, 1);
    pme_ack = 1'b1; step(1); pme_ack = 1'b0;
    check(pme == 1'b0, "R11 pme cleared by ack", pme, 0);
    bring_up("R9 link back");
  endtask

  // R3: cold request overrides power-down gap
  task automatic t_cold_override();
    int n;
    codec_ready = 1'b0;
    pulse_pd(); step(100);
    pulse_cold();
    check(ac_rst_n == 1'b0, "R3 cold overrides", ac_rst_n, 0);
    n = 1;
    while (!ac_rst_n && n < 500) begin step(1); n++; end
    check(n >= RSTC && n <= RSTC + 2, "R3 cold width", n, RSTC);
    bring_up("R3 link back after cold");
  endtask

  initial begin
    step(2);
    t_reset();
    step(5);
    t_bclk();
    t_active_ignores();
    t_host_warm();
    t_pending_bclk();
    t_wake();
    t_cold_override();
    step(10);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule